// File: doc/BRIEF.md
# Byte/Word Memory Access Unit

This unit is the load/store path between a 16-bit processor datapath and a 16-bit memory bus. The controller presents one request for a single cycle. The request carries the direction, the access size, the extension choice for byte loads, an addressing mode and the operands that mode needs. The unit forms the effective address and checks that it is aligned. It then places store data on the correct byte lane with byte enables and holds the bus until memory signals ready. Finally it returns either the loaded value or a fault, together with a one-cycle completion pulse.

Byte lanes are big-endian. The byte at an even address travels on data bits 15:8 and the byte at an odd address travels on bits 7:0. A word access to an odd address is refused before any bus cycle begins. The unit contains no memory of its own and no instruction-fetch sequencing.

Top module: `mem_access_unit`

## Requirements
- R1: With `req_mode` = 0 (register mode), the bus address is `req_base`.
- R2: With `req_mode` = 1 (absolute mode), the bus address is `req_imm`.
- R3: With `req_mode` = 2 (register plus displacement), the bus address is `req_base + req_imm` modulo 65536.
- R4: With `req_mode` = 3 (PC plus displacement), the bus address is `req_pc + req_imm` modulo 65536. A wrap past 0xFFFF raises no fault.
- R5: A word store (`req_byte`=0) drives `mem_wdata` = `req_wdata`, `mem_be` = 2'b11 and `mem_we` = 1.
- R6: A byte store drives `req_wdata[7:0]` onto both lanes and sets exactly one enable: `mem_be` = 2'b10 (bit 1 = lane 15:8) for an even address, 2'b01 for an odd address. The other byte of that memory word is left unchanged.
- R7: A byte load with `req_signed`=0 returns the addressed lane (15:8 if even, 7:0 if odd) in bits 7:0, with bits 15:8 cleared.
- R8: A byte load with `req_signed`=1 copies bit 7 of the loaded byte into bits 15:8.
- R9: A word load returns `mem_rdata` unchanged.
- R10: A word request to an odd address asserts `bus_err` together with `done` in the cycle after the request. It never raises `mem_en` and leaves memory unchanged.
- R11: `mem_en` stays high, with address, enables and data stable, until `mem_ready` is seen. `done` then pulses for exactly one cycle on the following cycle.
- R12: After reset, `mem_en`, `done` and `bus_err` are low.
- R13: A byte access to an odd address never faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe, taken when the unit is idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_signed | input | 1 | Byte loads: 1 = sign-extend, 0 = zero-extend |
| req_mode | input | 2 | 0 register, 1 absolute, 2 register+disp, 3 PC+disp |
| req_base | input | 16 | Base register value |
| req_imm | input | 16 | Immediate address or displacement |
| req_pc | input | 16 | Program counter value |
| req_wdata | input | 16 | Store data (byte stores use bits 7:0) |
| done | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Alignment fault, valid with done |
| rdata | output | 16 | Load result, valid from done on |
| mem_en | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 16 | Byte address |
| mem_be | output | 2 | Lane enables, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | Lane-placed write data |
| mem_rdata | input | 16 | Read data from memory |
| mem_ready | input | 1 | Memory completes the active cycle |

## Verification
The unit accepts a new request in the same cycle that it pulses `done` for the previous one. A fault completion and a fresh acceptance can therefore share a cycle. The bench provokes this case by issuing a misaligned word load and driving a valid byte load while `bus_err` and `done` are high. The overlap is judged correct when three things hold: the fault shows no bus activity, `done` drops in the next cycle while the second access runs, and the second access returns its correctly extended byte without an error.

// File: rtl/mau_pkg.sv
`timescale 1ns/1ps
package mau_pkg;
  typedef enum logic [1:0] {
    AM_REG      = 2'd0,
    AM_ABS      = 2'd1,
    AM_REG_DISP = 2'd2,
    AM_PC_DISP  = 2'd3
  } amode_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } mau_state_e;
endpackage

// File: rtl/mau_agen.sv
`timescale 1ns/1ps
module mau_agen
  import mau_pkg::*;
#(
  parameter int AW = 16
) (
  input  amode_e        mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] ea
);
  // Effective address; sums drop the carry so wrap is silent.
  function automatic logic [AW-1:0] calc_ea(input amode_e m, input logic [AW-1:0] b,
                                            input logic [AW-1:0] i, input logic [AW-1:0] p);
    case (m)
      AM_REG:      return b;
      AM_ABS:      return i;
      AM_REG_DISP: return b + i;
      default:     return p + i;
    endcase
  endfunction

  assign ea = calc_ea(mode, base, imm, pc);
endmodule

// File: rtl/mau_store_lane.sv
`timescale 1ns/1ps
module mau_store_lane #(
  parameter int DW = 16
) (
  input  logic                     byte_op,
  input  logic [LB-1:0]            lane,
  input  logic [DW-1:0]            wdata,
  output logic [LANES-1:0]         be,
  output logic [DW-1:0]            lanes_out
);
  localparam int LANES = DW / 8;
  localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1;

  // Big-endian: lane index g (address offset) lives at the top for g = 0.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[LANES-1-g]             = !byte_op || (lane == LB'(g));
    assign lanes_out[DW-1-8*g -: 8]  = byte_op ? wdata[7:0] : wdata[DW-1-8*g -: 8];
  end
endmodule

// File: rtl/mau_load_align.sv
`timescale 1ns/1ps
module mau_load_align #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] word_in,
  input  logic [LB-1:0] lane,
  input  logic          byte_op,
  input  logic          sign_ext,
  output logic [DW-1:0] result
);
  localparam int LANES = DW / 8;
  localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1;

  function automatic logic [DW-1:0] align_load(input logic [DW-1:0] w, input logic [LB-1:0] idx,
                                               input logic is_byte, input logic sx);
    logic [7:0] b;
    b = '0;
    for (int k = 0; k < LANES; k++) begin
      if (idx == LB'(k)) b = w[DW-1-8*k -: 8];
    end
    if (!is_byte) return w;
    return {{(DW-8){sx & b[7]}}, b};
  endfunction

  assign result = align_load(word_in, lane, byte_op, sign_ext);
endmodule

// File: rtl/mau_ctrl.sv
`timescale 1ns/1ps
module mau_ctrl
  import mau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic fault,
  input  logic mem_ready,
  output logic accept,
  output logic reject,
  output logic complete,
  output logic access_active,
  output logic done,
  output logic bus_err
);
  mau_state_e state_q;

  assign access_active = (state_q == ST_ACCESS);
  assign accept        = (state_q == ST_IDLE) && req_valid && !fault;
  assign reject        = (state_q == ST_IDLE) && req_valid &&  fault;
  assign complete      = access_active && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      done    <= complete || reject;
      bus_err <= reject;
      if (accept)        state_q <= ST_ACCESS;
      else if (complete) state_q <= ST_IDLE;
    end
  end

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> done);
  assert_fault_no_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !access_active);
  assert_done_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bus_err) |-> $past(access_active && mem_ready));
endmodule

// File: rtl/mem_access_unit.sv
`timescale 1ns/1ps
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic          req_signed,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_base,
  input  logic [AW-1:0] req_imm,
  input  logic [AW-1:0] req_pc,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          bus_err,
  output logic [DW-1:0] rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready
);
  localparam int LANES = DW / 8;
  localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [AW-1:0]    ea;
  logic             misalign;
  logic [LANES-1:0] be_next;
  logic [DW-1:0]    wdata_next;
  logic [DW-1:0]    load_value;
  logic             accept, reject, complete, access_active;

  logic             byte_q, sgn_q;
  logic [LB-1:0]    lane_q;

  mau_agen #(.AW(AW)) u_agen (
    .mode (amode_e'(req_mode)),
    .base (req_base),
    .imm  (req_imm),
    .pc   (req_pc),
    .ea   (ea)
  );

  assign misalign = !req_byte && (ea[LB-1:0] != '0);

  mau_store_lane #(.DW(DW)) u_store (
    .byte_op   (req_byte),
    .lane      (ea[LB-1:0]),
    .wdata     (req_wdata),
    .be        (be_next),
    .lanes_out (wdata_next)
  );

  mau_load_align #(.DW(DW)) u_load (
    .word_in  (mem_rdata),
    .lane     (lane_q),
    .byte_op  (byte_q),
    .sign_ext (sgn_q),
    .result   (load_value)
  );

  mau_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .fault         (misalign),
    .mem_ready     (mem_ready),
    .accept        (accept),
    .reject        (reject),
    .complete      (complete),
    .access_active (access_active),
    .done          (done),
    .bus_err       (bus_err)
  );

  assign mem_en = access_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      byte_q    <= 1'b0;
      sgn_q     <= 1'b0;
      lane_q    <= '0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        mem_we    <= req_write;
        mem_addr  <= ea;
        mem_be    <= be_next;
        mem_wdata <= wdata_next;
        byte_q    <= req_byte;
        sgn_q     <= req_signed;
        lane_q    <= ea[LB-1:0];
      end
      if (complete && !mem_we) rdata <= load_value;
    end
  end

  assert_hold_until_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_ready) |=> (mem_en && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));
  assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && byte_q) |-> ($countones(mem_be) == 1));
  assert_word_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !byte_q) |-> (mem_addr[LB-1:0] == '0 && mem_be == '1));
  assert_sign_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bus_err && !mem_we && byte_q && sgn_q) |-> (rdata[DW-1:8] == {(DW-8){rdata[7]}}));
  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !bus_err && !mem_we && byte_q && !sgn_q) |-> (rdata[DW-1:8] == '0));
endmodule

// File: tb/mem_access_unit_bench.sv
`timescale 1ns/1ps
module mem_access_unit_bench;
  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_byte = 0, req_signed = 0;
  logic [1:0]  req_mode = 0;
  logic [15:0] req_base = 0, req_imm = 0, req_pc = 0, req_wdata = 0;
  logic        done, bus_err, mem_en, mem_we;
  logic [15:0] rdata, mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_be;
  logic        mem_ready = 0;

  mem_access_unit u_mem_access_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_signed(req_signed), .req_mode(req_mode),
    .req_base(req_base), .req_imm(req_imm), .req_pc(req_pc), .req_wdata(req_wdata),
    .done(done), .bus_err(bus_err), .rdata(rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  // Memory model: 128 words, big-endian lanes.
  logic [15:0] mem [0:127];
  int          wait_n = 0;
  int          wcnt = 0;
  int          en_count = 0;
  logic [15:0] cap_addr, cap_wdata;
  logic [1:0]  cap_be;
  logic        cap_we;

  function automatic logic [15:0] init_word(input int w);
    return {8'(8'h80 + w), 8'(8'h10 + w)};
  endfunction

  assign mem_rdata = mem[mem_addr[7:1]];

  always @(posedge clk) begin
    if (mem_en) en_count <= en_count + 1;
    if (mem_en && !mem_ready) begin
      if (wcnt >= wait_n) mem_ready <= 1'b1;
      else wcnt <= wcnt + 1;
    end else if (mem_en && mem_ready) begin
      mem_ready <= 1'b0;
      wcnt      <= 0;
      cap_addr  <= mem_addr;
      cap_be    <= mem_be;
      cap_wdata <= mem_wdata;
      cap_we    <= mem_we;
      if (mem_we) begin
        if (mem_be[1]) mem[mem_addr[7:1]][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) mem[mem_addr[7:1]][7:0]  <= mem_wdata[7:0];
      end
    end
  end

  int checks = 0, fails = 0;
  logic [15:0] got_rdata;
  logic        got_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic byt, input logic sg, input logic [1:0] md,
                       input logic [15:0] b, input logic [15:0] i, input logic [15:0] p,
                       input logic [15:0] wd);
    req_write = wr; req_byte = byt; req_signed = sg; req_mode = md;
    req_base = b; req_imm = i; req_pc = p; req_wdata = wd; req_valid = 1;
  endtask

  // Issue at a negedge; return at the negedge where done is high.
  task automatic run(input logic wr, input logic byt, input logic sg, input logic [1:0] md,
                     input logic [15:0] b, input logic [15:0] i, input logic [15:0] p,
                     input logic [15:0] wd);
    int n;
    en_count = 0;
    drive(wr, byt, sg, md, b, i, p, wd);
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("watchdog access", 0, 1);
    got_rdata = rdata;
    got_err   = bus_err;
  endtask

  task automatic check_pulse_ends(input string tag);
    @(negedge clk);
    chk(tag, {31'd0, done}, 0);
  endtask

  task automatic t_reset;
    chk("R12 mem_en after reset", {31'd0, mem_en}, 0);
    chk("R12 done after reset", {31'd0, done}, 0);
    chk("R12 bus_err after reset", {31'd0, bus_err}, 0);
  endtask

  task automatic t_word_reg;
    run(0, 0, 0, 2'd0, 16'h0010, 16'h0, 16'h0, 16'h0);
    chk("R1 address", cap_addr, 16'h0010);
    chk("R9 word load", got_rdata, 16'h8818);
    chk("R9 word be", cap_be, 2'b11);
    chk("R9 no error", got_err, 0);
    check_pulse_ends("R11 done one cycle");
  endtask

  task automatic t_byte_abs_odd;
    run(0, 1, 0, 2'd1, 16'hDEAD, 16'h0021, 16'h0, 16'h0);
    chk("R2 address", cap_addr, 16'h0021);
    chk("R7 odd lane zero-ext", got_rdata, 16'h0020);
    chk("R13 odd byte no fault", got_err, 0);
    chk("R6 odd be", cap_be, 2'b01);
  endtask

  task automatic t_byte_disp_even;
    run(0, 1, 1, 2'd2, 16'h0030, 16'h0004, 16'h0, 16'h0);
    chk("R3 address", cap_addr, 16'h0034);
    chk("R8 even lane sign-ext", got_rdata, 16'hFF9A);
    run(0, 1, 0, 2'd2, 16'h0030, 16'h0004, 16'h0, 16'h0);
    chk("R7 even lane zero-ext", got_rdata, 16'h009A);
    run(0, 1, 1, 2'd1, 16'h0, 16'h0035, 16'h0, 16'h0);
    chk("R8 positive byte stays positive", got_rdata, 16'h002A);
  endtask

  task automatic t_pc_wrap;
    run(0, 0, 0, 2'd3, 16'h1111, 16'h0020, 16'hFFF0, 16'h0);
    chk("R4 wrapped address", cap_addr, 16'h0010);
    chk("R4 no fault on wrap", got_err, 0);
    chk("R4 data", got_rdata, 16'h8818);
  endtask

  task automatic t_stores;
    run(1, 0, 0, 2'd2, 16'h0040, 16'h0002, 16'h0, 16'hBEEF);
    chk("R5 we", cap_we, 1);
    chk("R5 be", cap_be, 2'b11);
    chk("R5 wdata", cap_wdata, 16'hBEEF);
    run(0, 0, 0, 2'd1, 16'h0, 16'h0042, 16'h0, 16'h0);
    chk("R5 readback", got_rdata, 16'hBEEF);
    run(1, 1, 0, 2'd1, 16'h0, 16'h0045, 16'h0, 16'h1234);
    chk("R6 odd wdata both lanes", cap_wdata, 16'h3434);
    chk("R6 odd be", cap_be, 2'b01);
    run(0, 0, 0, 2'd1, 16'h0, 16'h0044, 16'h0, 16'h0);
    chk("R6 odd store keeps high byte", got_rdata, 16'hA234);
    run(1, 1, 0, 2'd0, 16'h0046, 16'h0, 16'h0, 16'h00C3);
    chk("R6 even be", cap_be, 2'b10);
    run(0, 0, 0, 2'd0, 16'h0046, 16'h0, 16'h0, 16'h0);
    chk("R6 even store keeps low byte", got_rdata, 16'hC333);
  endtask

  task automatic t_misalign;
    run(0, 0, 0, 2'd0, 16'h0011, 16'h0, 16'h0, 16'h0);
    chk("R10 load fault", got_err, 1);
    chk("R10 no bus cycle", en_count, 0);
    check_pulse_ends("R10 fault done one cycle");
    run(1, 0, 0, 2'd3, 16'h0, 16'h0003, 16'h0010, 16'hFFFF);
    chk("R10 store fault", got_err, 1);
    chk("R10 no bus cycle on store", en_count, 0);
    run(0, 0, 0, 2'd0, 16'h0012, 16'h0, 16'h0, 16'h0);
    chk("R10 memory untouched", got_rdata, 16'h8919);
  endtask

  task automatic t_wait_states;
    wait_n = 3;
    run(0, 0, 0, 2'd0, 16'h0020, 16'h0, 16'h0, 16'h0);
    chk("R11 held through wait", en_count, 5);
    chk("R11 data after wait", got_rdata, 16'h9020);
    check_pulse_ends("R11 done one cycle after wait");
    wait_n = 0;
  endtask

  task automatic t_back_to_back;
    int n;
    run(0, 0, 0, 2'd1, 16'h0, 16'h0023, 16'h0, 16'h0);
    chk("R10 first fault", got_err, 1);
    drive(0, 1, 1, 2'd1, 16'h0, 16'h0024, 16'h0, 16'h0);
    en_count = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R11 done low during second access", done, 0);
    chk("R11 second access started", mem_en, 1);
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R8 second access result", rdata, 16'hFF92);
    chk("R13 second access no error", bus_err, 0);
  endtask

  initial begin
    for (int w = 0; w < 128; w++) mem[w] = init_word(w);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_word_reg;
    t_byte_abs_odd;
    t_byte_disp_even;
    t_pc_wrap;
    t_stores;
    t_misalign;
    t_wait_states;
    t_back_to_back;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule